// File: doc/BRIEF.md
# Multiple Register Load Sequencer

This block fills a contiguous run of general registers from consecutive word locations in memory. A single-cycle start pulse supplies a first register number, a last register number and a byte address. The sequencer then issues one word read per register over a request/response memory port. Each good response is written straight into the register file through a write port. Register numbers climb by one and wrap from the highest index back to zero. Every pairing of first and last is legal. Equal numbers move a single word. A last number one below the first moves the whole file.

The memory port carries at most one read at a time. A request stays up, with a steady address, until the memory accepts it. The next request is issued only after the response to the previous one has arrived. An error on any response ends the sequence at once: that word and every later word are left unwritten, and a fault pulse is raised in place of the done pulse. The block has no flag or condition output that the operation could change.

Top module: `multi_reg_loader`

## Requirements
- R1: After reset, and whenever no sequence is running, `busy`, `memReq`, `rfWrEn`, `done` and `fault` are all 0.
- R2: Register writes go in ascending index order. They start at `firstReg` and step by one modulo 16, so index 0 follows index 15.
- R3: A sequence without an error writes exactly ((lastReg − firstReg) mod 16) + 1 registers: one when the two numbers are equal, sixteen when lastReg = firstReg − 1 mod 16.
- R4: The first read goes to `baseAddr`. Each later read goes to the previous read's address plus 4. The word written for the k-th register (counting from 0) is the response data for address `baseAddr` + 4·k.
- R5: A request with `memReq` high and `memReqReady` low keeps `memReq` high and `memAddr` unchanged in the next cycle. After an accepted request, `memReq` is low in the next cycle, so only one read is outstanding.
- R6: `done` is a one-cycle pulse in the cycle after the write of the last register. In that same cycle `busy` is 0.
- R7: A response with `memRspErr` = 1 writes nothing, and no further request or write follows it. `fault` pulses for one cycle in the next cycle, and `done` is not raised for that sequence.
- R8: A `startPulse` while `busy` is 1 has no effect: the running sequence keeps its register range and addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Starts a sequence when idle |
| firstReg | input | 4 | First register number to load |
| lastReg | input | 4 | Last register number to load (inclusive) |
| baseAddr | input | 32 | Byte address of the first word |
| memReq | output | 1 | Read request valid |
| memAddr | output | 32 | Read byte address |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memRspValid | input | 1 | Read response present |
| memRspData | input | 32 | Read response word |
| memRspErr | input | 1 | Read response carries an access error |
| rfWrEn | output | 1 | Register file write enable |
| rfWrIdx | output | 4 | Register file write index |
| rfWrData | output | 32 | Register file write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: sequence completed |
| fault | output | 1 | One-cycle pulse: sequence ended by an access error |

## Verification
If the register pointer is wrong, the write index is wrong on the very first write, or it drifts from the ascending pattern on the next write. If the remaining-word counter is wrong, the number of writes between start and `done` changes, which shows when the sequence ends. If the address register is wrong, `memAddr` is wrong on the next accepted request. If the sequencing state is wrong, a second request appears while a read is outstanding, a write follows an error response, or a pulse goes missing; each of these is visible within one cycle of the response that triggers it.

// File: rtl/mrl_pkg.sv
package mrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } mrlState_t;

  typedef struct packed {
    logic load;     // capture range and address
    logic advance;  // step pointer, address and remaining count
  } mrlStrobe_t;
endpackage

// File: rtl/mrl_datapath.sv
module mrl_datapath #(
  parameter int ADDR_W     = 32,
  parameter int REG_COUNT  = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = $clog2(REG_COUNT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  mrl_pkg::mrlStrobe_t strobe,
  input  logic [IDX_W-1:0]    firstReg,
  input  logic [IDX_W-1:0]    lastReg,
  input  logic [ADDR_W-1:0]   baseAddr,
  output logic [ADDR_W-1:0]   curAddr,
  output logic [IDX_W-1:0]    curIdx,
  output logic                lastWord
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);

  logic [IDX_W-1:0]  ptrQ;
  logic [IDX_W-1:0]  remainQ;
  logic [ADDR_W-1:0] addrQ;

  // Index arithmetic wraps naturally in IDX_W bits (REG_COUNT a power of two).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ    <= '0;
      remainQ <= '0;
      addrQ   <= '0;
    end else if (strobe.load) begin
      ptrQ    <= firstReg;
      remainQ <= lastReg - firstReg;
      addrQ   <= baseAddr;
    end else if (strobe.advance) begin
      ptrQ    <= ptrQ + 1'b1;
      remainQ <= remainQ - 1'b1;
      addrQ   <= addrQ + ADDR_STEP;
    end
  end

  assign curAddr  = addrQ;
  assign curIdx   = ptrQ;
  assign lastWord = (remainQ == '0);
endmodule

// File: rtl/mrl_ctrl.sv
module mrl_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic                memReqReady,
  input  logic                memRspValid,
  input  logic                memRspErr,
  input  logic                lastWord,
  output mrl_pkg::mrlStrobe_t strobe,
  output logic                memReq,
  output logic                rfWrEn,
  output logic                busy,
  output logic                done,
  output logic                fault
);
  import mrl_pkg::*;

  mrlState_t stateQ, stateD;
  logic      doneQ, faultQ;
  logic      rspOk, rspBad;

  assign rspOk  = (stateQ == ST_WAIT) && memRspValid && !memRspErr;
  assign rspBad = (stateQ == ST_WAIT) && memRspValid && memRspErr;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (startPulse) stateD = ST_REQ;
      ST_REQ:  if (memReqReady) stateD = ST_WAIT;
      ST_WAIT: begin
        if (rspBad) stateD = ST_IDLE;
        else if (rspOk) stateD = lastWord ? ST_IDLE : ST_REQ;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= rspOk && lastWord;
      faultQ <= rspBad;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.load    = (stateQ == ST_IDLE) && startPulse;
    strobe.advance = rspOk;
  end

  assign memReq = (stateQ == ST_REQ);
  assign rfWrEn = rspOk;
  assign busy   = (stateQ != ST_IDLE);
  assign done   = doneQ;
  assign fault  = faultQ;
endmodule

// File: rtl/multi_reg_loader.sv
module multi_reg_loader #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 16,
  localparam int IDX_W = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [IDX_W-1:0]  firstReg,
  input  logic [IDX_W-1:0]  lastReg,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              memRspErr,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              busy,
  output logic              done,
  output logic              fault
);
  localparam int WORD_BYTES = DATA_W / 8;

  mrl_pkg::mrlStrobe_t strobe;
  logic                lastWord;

  mrl_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memRspErr   (memRspErr),
    .lastWord    (lastWord),
    .strobe      (strobe),
    .memReq      (memReq),
    .rfWrEn      (rfWrEn),
    .busy        (busy),
    .done        (done),
    .fault       (fault)
  );

  mrl_datapath #(
    .ADDR_W     (ADDR_W),
    .REG_COUNT  (REG_COUNT),
    .WORD_BYTES (WORD_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .firstReg (firstReg),
    .lastReg  (lastReg),
    .baseAddr (baseAddr),
    .curAddr  (memAddr),
    .curIdx   (rfWrIdx),
    .lastWord (lastWord)
  );

  assign rfWrData = memRspData;
endmodule

// File: rtl/multi_reg_loader_checker.sv
module multi_reg_loader_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memReqReady,
  input logic              memRspValid,
  input logic              memRspErr,
  input logic              rfWrEn,
  input logic [IDX_W-1:0]  rfWrIdx,
  input logic              busy,
  input logic              done,
  input logic              fault
);
  logic             wrSeen;
  logic [IDX_W-1:0] prevIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSeen  <= 1'b0;
      prevIdx <= '0;
    end else if (!busy) begin
      wrSeen  <= 1'b0;
    end else if (rfWrEn) begin
      wrSeen  <= 1'b1;
      prevIdx <= rfWrIdx;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !rfWrEn)); // R1
  AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && wrSeen) |-> (rfWrIdx == IDX_W'(prevIdx + 1'b1))); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |=> (memAddr == $past(memAddr) + ADDR_W'(4))); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReqReady) |=> (memReq && $stable(memAddr))); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReqReady) |=> !memReq); // R5
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(rfWrEn) && !busy)); // R6
  AST_WRITE_NEEDS_OK: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (memRspValid && !memRspErr)); // R7
  AST_FAULT_AFTER_ERR: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> ($past(memRspValid && memRspErr && busy) && !done && !busy)); // R7
endmodule

bind multi_reg_loader multi_reg_loader_checker #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W)
) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .memReq      (memReq),
  .memAddr     (memAddr),
  .memReqReady (memReqReady),
  .memRspValid (memRspValid),
  .memRspErr   (memRspErr),
  .rfWrEn      (rfWrEn),
  .rfWrIdx     (rfWrIdx),
  .busy        (busy),
  .done        (done),
  .fault       (fault)
);

// File: tb/multi_reg_loader_bench.sv
`timescale 1ns/1ps
module multi_reg_loader_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [3:0]  firstReg = '0;
  logic [3:0]  lastReg = '0;
  logic [31:0] baseAddr = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memReqReady;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        memRspErr;
  logic        rfWrEn;
  logic [3:0]  rfWrIdx;
  logic [31:0] rfWrData;
  logic        busy, done, fault;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk; // 50 MHz

  multi_reg_loader u_multi_reg_loader (.*);

  // ---------------- memory model ----------------
  logic stallMode = 1'b0;
  int   faultWord = -1;
  logic readyQ;

  function automatic logic [31:0] wordAt(input logic [29:0] w);
    return {w[7:0] ^ 8'h5A, w[15:8], 16'hC3A5 ^ w[15:0]};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ      <= 1'b0;
      memRspValid <= 1'b0;
      memRspData  <= '0;
      memRspErr   <= 1'b0;
    end else begin
      readyQ      <= stallMode ? ~readyQ : 1'b1;
      memRspValid <= memReq && memReqReady;
      memRspData  <= wordAt(memAddr[31:2]);
      memRspErr   <= memReq && memReqReady && (int'(memAddr[31:2]) == faultWord);
    end
  end
  assign memReqReady = readyQ;

  // ---------------- monitor ----------------
  int          wrCount = 0;
  int          reqCount = 0;
  logic [3:0]  logIdx [32];
  logic [31:0] logData [32];
  logic [31:0] expBase = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rfWrEn) begin
      if (wrCount < 32) begin
        logIdx[wrCount]  = rfWrIdx;
        logData[wrCount] = rfWrData;
      end
      wrCount++;
    end
    if (memReq && memReqReady) begin
      check(memAddr == expBase + 32'(4 * reqCount), "R4", "request address",
            memAddr, expBase + 32'(4 * reqCount));
      reqCount++;
    end
  end

  // ---------------- one sequence ----------------
  task automatic runOp(input logic [3:0] f, input logic [3:0] l,
                       input logic [7:0] baseW, input int faultPos,
                       input bit stall, input bit interfere);
    int  expN, expWr, n;
    bit  sawDone, sawFault;
    expN      = int'(4'(l - f)) + 1;
    expWr     = (faultPos >= 0) ? faultPos : expN;
    faultWord = (faultPos >= 0) ? int'(baseW) + faultPos : -1;
    stallMode = stall;
    @(negedge clk);
    wrCount   = 0;
    reqCount  = 0;
    expBase   = {22'd0, baseW, 2'b00};
    firstReg  = f;
    lastReg   = l;
    baseAddr  = expBase;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    sawDone = 1'b0;
    sawFault = 1'b0;
    n = 0;
    while (n < 300) begin
      if (interfere && n == 3) begin
        firstReg = f + 4'd7; lastReg = f + 4'd8; baseAddr = 32'h400;
        startPulse = 1'b1; // R8: must be ignored while busy
      end else begin
        startPulse = 1'b0;
      end
      if (done) sawDone = 1'b1;
      if (fault) sawFault = 1'b1;
      if (done || fault) break;
      @(negedge clk);
      n++;
    end
    startPulse = 1'b0;
    check(busy == 1'b0, "R6", "busy at completion pulse", busy, 0);
    repeat (3) @(negedge clk);
    check(!busy && !memReq, "R1", "idle after sequence", {busy, memReq}, 0);
    check(wrCount == expWr, (faultPos >= 0) ? "R7" : "R3", "write count",
          wrCount, expWr);
    check(sawDone == (faultPos < 0), "R6", "done pulse seen", sawDone, faultPos < 0);
    check(sawFault == (faultPos >= 0), "R7", "fault pulse seen", sawFault, faultPos >= 0);
    for (int k = 0; k < expWr && k < wrCount && k < 32; k++) begin
      check(logIdx[k] == 4'(f + 4'(k)), interfere ? "R8" : "R2", "write index",
            logIdx[k], 4'(f + 4'(k)));
      check(logData[k] == wordAt(30'(baseW) + 30'(k)), "R4", "write data",
            logData[k], wordAt(30'(baseW) + 30'(k)));
    end
  endtask

  // ---------------- vectors ----------------
  localparam int NV = 9;
  localparam logic [3:0] V_FIRST [NV] = '{4'd3, 4'd5, 4'd14, 4'd0, 4'd9, 4'd15, 4'd2, 4'd11, 4'd7};
  localparam logic [3:0] V_LAST  [NV] = '{4'd7, 4'd5, 4'd2,  4'd15, 4'd8, 4'd0, 4'd6, 4'd11, 4'd6};
  localparam logic [7:0] V_BASEW [NV] = '{8'h04, 8'h10, 8'h20, 8'h00, 8'h33, 8'h80, 8'h44, 8'h50, 8'h60};
  localparam int         V_FAULT [NV] = '{-1, -1, -1, -1, -1, -1, 2, 0, 15};
  localparam bit         V_STALL [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, memReq, rfWrEn, done, fault} == 5'b0, "R1", "outputs in reset",
          {busy, memReq, rfWrEn, done, fault}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, memReq, rfWrEn, done, fault} == 5'b0, "R1", "outputs idle after reset",
          {busy, memReq, rfWrEn, done, fault}, 0);

    // R2 R3 R4 R5 R6 R7: table walk (wrap, equal, full, stalls, faults)
    for (int v = 0; v < NV; v++)
      runOp(V_FIRST[v], V_LAST[v], V_BASEW[v], V_FAULT[v], V_STALL[v], 1'b0);

    // R8: start while busy on a full-file run
    runOp(4'd4, 4'd3, 8'h70, -1, 1'b1, 1'b1);

    // R7: fault on the last word of a wrapped range
    runOp(4'd13, 4'd1, 8'h90, 4, 1'b0, 1'b0);

    // R1: idle port state is steady with no start
    repeat (4) @(negedge clk);
    check(!busy && !memReq && !rfWrEn, "R1", "idle without start",
          {busy, memReq, rfWrEn}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule